// File: doc/BRIEF.md
# Byte/Word Switchable Memory Bus Front End

This block sits between the pins of an asynchronous parallel memory and its internal storage. Each cycle it samples active-low chip select, output enable and write strobe, a word address, a width-select pin, an identifier-mode flag and the 16-bit data bus. From these it produces internal word reads and writes that carry a per-byte lane mask. On reads it steers the array word, or one of two fixed identifier codes, onto the data bus. The tri-state control is a separate per-bit enable vector, so the pad ring needs no further decoding.

When the width pin is low the part runs 8 bits wide. Only the low eight data pins carry data, and the topmost data pin acts as an extra, least significant address bit. That bit chooses the upper or lower half of the addressed internal word. When the width pin is high, all sixteen pins carry one word. Writes take effect at the rising edge of the write strobe, using the address and data present while the strobe was low.

Top module: `bw_bus_front`

## Requirements
- R1: In 8-bit mode (x16_sel = 0), a read drives dq_out[7:0] with the upper byte of the word at addr when dq_in[15] is 1 and with the lower byte when it is 0. dq_out[15:8] is 0 and dq_oe is 16'h00FF.
- R2: In 16-bit mode (x16_sel = 1), a read drives the whole word on dq_out with dq_oe = 16'hFFFF.
- R3: dq_oe is all zero whenever ce_n or oe_n was high at the last sampling edge.
- R4: oe_n has no effect while we_n is low: dq_oe stays all zero during a write strobe.
- R5: A write completes when the sampled we_n goes from low (with ce_n low) to high. mem_wr_en then pulses for exactly one cycle in the following cycle. Address and data come from the last low-strobe sample, and mem_wr_en never rises while we_n is low.
- R6: An 8-bit write copies dq_in[7:0] onto both byte lanes of mem_wr_data. mem_wr_be is 2'b10 when dq_in[15] was 1 and 2'b01 when it was 0, so the byte address is {addr, dq_in[15]}.
- R7: A 16-bit write passes dq_in unchanged with mem_wr_be = 2'b11.
- R8: With id_mode high, a read returns MFR_ID when addr[0] is 0 and DEV_ID when addr[0] is 1. mem_rd_en stays low.
- R9: An identifier read in 8-bit mode returns only the low byte of the code, with dq_oe = 16'h00FF.
- R10: While reset is asserted, dq_oe is all zero and mem_wr_en is low.
- R11: Read outputs follow the pins sampled at the previous rising clock edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| x16_sel | input | 1 | Width select: 1 = 16-bit, 0 = 8-bit |
| id_mode | input | 1 | Identifier read mode |
| addr | input | AW | Word address pins |
| dq_in | input | 16 | Data bus as seen at the pads |
| dq_out | output | 16 | Data bus output values |
| dq_oe | output | 16 | Per-bit output enable for the data pads |
| mem_rd_en | output | 1 | Internal array read request |
| mem_rd_addr | output | AW | Internal word read address |
| mem_rd_data | input | 16 | Internal array read word |
| mem_wr_en | output | 1 | One-cycle internal write strobe |
| mem_wr_addr | output | AW | Internal word write address |
| mem_wr_data | output | 16 | Internal write word |
| mem_wr_be | output | 2 | Byte lane mask, bit 1 = upper byte |

## Verification
The assertions assume all pins are already synchronous to clk and that the internal array returns read data in the same cycle the address is presented. They also assume ce_n stays low for the whole of a write strobe. The stimulus changes pins only on falling clock edges. It holds ce_n low from the fall of we_n until after its rise, and it models the array as a fixed combinational function of the read address. Every sampled pin combination is therefore a legal, stable one.

// File: rtl/bw_bus_pkg.sv
package bw_bus_pkg;
  localparam int DQ_W   = 16;
  localparam int LANE_W = DQ_W / 2;
  localparam int BE_W   = DQ_W / LANE_W;

  typedef enum logic {
    WIDTH_X8  = 1'b0,
    WIDTH_X16 = 1'b1
  } bus_width_e;
endpackage

// File: rtl/bw_rd_steer.sv
module bw_rd_steer
  import bw_bus_pkg::*;
#(
  parameter logic [DQ_W-1:0] MFR_ID = 16'h00B7,
  parameter logic [DQ_W-1:0] DEV_ID = 16'h5A3C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic            we_n,
  input  bus_width_e      width,
  input  logic            id_sel,
  input  logic            addr_lsb,
  input  logic            lane_hi,
  input  logic [DQ_W-1:0] rd_data,
  output logic [DQ_W-1:0] dq_out,
  output logic [DQ_W-1:0] dq_oe
);
  logic [DQ_W-1:0] src_word;
  logic [DQ_W-1:0] out_d, out_q;
  logic [DQ_W-1:0] oe_d, oe_q;
  logic            drive_en;

  assign drive_en = ~ce_n & ~oe_n & we_n;

  always_comb begin
    src_word = id_sel ? (addr_lsb ? DEV_ID : MFR_ID) : rd_data;
    out_d    = '0;
    oe_d     = '0;
    if (drive_en) begin
      if (width == WIDTH_X16) begin
        out_d = src_word;
        oe_d  = '1;
      end else begin
        oe_d[LANE_W-1:0] = '1;
        if (!id_sel && lane_hi) out_d[LANE_W-1:0] = src_word[DQ_W-1:LANE_W];
        else                    out_d[LANE_W-1:0] = src_word[LANE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = oe_q;
endmodule

// File: rtl/bw_wr_capture.sv
module bw_wr_capture
  import bw_bus_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            we_n,
  input  bus_width_e      width,
  input  logic [AW-1:0]   addr,
  input  logic [DQ_W-1:0] dq_in,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [DQ_W-1:0] wr_data,
  output logic [BE_W-1:0] wr_be
);
  logic            strobe_low;
  logic            low_q;
  logic            rise;
  logic [AW-1:0]   hold_addr;
  logic [DQ_W-1:0] hold_data;
  bus_width_e      hold_width;
  logic [DQ_W-1:0] data_d;
  logic [BE_W-1:0] be_d;
  logic            en_q;
  logic [AW-1:0]   addr_q;
  logic [DQ_W-1:0] data_q;
  logic [BE_W-1:0] be_q;

  assign strobe_low = ~we_n & ~ce_n;
  assign rise       = low_q & we_n;

  always_comb begin
    if (hold_width == WIDTH_X16) begin
      data_d = hold_data;
      be_d   = '1;
    end else begin
      data_d = {hold_data[LANE_W-1:0], hold_data[LANE_W-1:0]};
      be_d   = hold_data[DQ_W-1] ? 2'b10 : 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      low_q <= strobe_low;
      en_q  <= rise;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe_low) begin
      hold_addr  <= addr;
      hold_data  <= dq_in;
      hold_width <= width;
    end
  end

  always_ff @(posedge clk) begin
    if (rise) begin
      addr_q <= hold_addr;
      data_q <= data_d;
      be_q   <= be_d;
    end
  end

  assign wr_en   = en_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
  assign wr_be   = be_q;
endmodule

// File: rtl/bw_bus_front.sv
module bw_bus_front
  import bw_bus_pkg::*;
#(
  parameter int              AW     = 18,
  parameter logic [DQ_W-1:0] MFR_ID = 16'h00B7,
  parameter logic [DQ_W-1:0] DEV_ID = 16'h5A3C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic            we_n,
  input  logic            x16_sel,
  input  logic            id_mode,
  input  logic [AW-1:0]   addr,
  input  logic [DQ_W-1:0] dq_in,
  output logic [DQ_W-1:0] dq_out,
  output logic [DQ_W-1:0] dq_oe,
  output logic            mem_rd_en,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic [DQ_W-1:0] mem_rd_data,
  output logic            mem_wr_en,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [DQ_W-1:0] mem_wr_data,
  output logic [BE_W-1:0] mem_wr_be
);
  logic       rst_meta_n, rst_sync_n;
  bus_width_e width;
  logic       lane_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign width       = x16_sel ? WIDTH_X16 : WIDTH_X8;
  assign lane_hi     = (width == WIDTH_X8) & dq_in[DQ_W-1];
  assign mem_rd_en   = ~ce_n & ~oe_n & we_n & ~id_mode;
  assign mem_rd_addr = addr;

  bw_rd_steer #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .width    (width),
    .id_sel   (id_mode),
    .addr_lsb (addr[0]),
    .lane_hi  (lane_hi),
    .rd_data  (mem_rd_data),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  bw_wr_capture #(.AW(AW)) u_wr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .width   (width),
    .addr    (addr),
    .dq_in   (dq_in),
    .wr_en   (mem_wr_en),
    .wr_addr (mem_wr_addr),
    .wr_data (mem_wr_data),
    .wr_be   (mem_wr_be)
  );
endmodule

// File: rtl/bw_bus_front_chk.sv
module bw_bus_front_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        x16_sel,
  input logic        id_mode,
  input logic [15:0] dq_out,
  input logic [15:0] dq_oe,
  input logic        mem_rd_en,
  input logic        mem_wr_en,
  input logic [15:0] mem_wr_data,
  input logic [1:0]  mem_wr_be
);
  a_r1_byte_mask: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ce_n && !oe_n && we_n && !x16_sel) |=> (dq_oe == 16'h00FF && dq_out[15:8] == 8'h00));

  a_r2_word_mask: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ce_n && !oe_n && we_n && x16_sel) |=> (dq_oe == 16'hFFFF));

  a_r3_float: assert property (@(posedge clk) disable iff (!rst_ok)
    (ce_n || oe_n) |=> (dq_oe == 16'h0000));

  a_r4_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_ok)
    !we_n |=> (dq_oe == 16'h0000));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_wr_en |=> !mem_wr_en);

  a_r5_none_while_low: assert property (@(posedge clk) disable iff (!rst_ok)
    !we_n |=> !mem_wr_en);

  a_r6_lane_mask: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_wr_en && mem_wr_be != 2'b11) |-> ($onehot(mem_wr_be) && mem_wr_data[15:8] == mem_wr_data[7:0]));

  a_r8_id_no_array: assert property (@(posedge clk) disable iff (!rst_ok)
    (id_mode && mem_rd_en) |-> 1'b0);
endmodule

bind bw_bus_front bw_bus_front_chk u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .ce_n        (ce_n),
  .oe_n        (oe_n),
  .we_n        (we_n),
  .x16_sel     (x16_sel),
  .id_mode     (id_mode),
  .dq_out      (dq_out),
  .dq_oe       (dq_oe),
  .mem_rd_en   (mem_rd_en),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_data (mem_wr_data),
  .mem_wr_be   (mem_wr_be)
);

// File: tb/bw_bus_front_tb.sv
`timescale 1ns/1ps
module bw_bus_front_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, x16_sel, id_mode;
  logic [AW-1:0] addr;
  logic [15:0]   dq_in;
  logic [15:0]   dq_out, dq_oe;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [15:0]   mem_rd_data;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [15:0]   mem_wr_data;
  logic [1:0]    mem_wr_be;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  // array model: word = {addr[7:0]^8'h3C, addr[15:8]}
  assign mem_rd_data = {mem_rd_addr[7:0] ^ 8'h3C, mem_rd_addr[15:8]};

  bw_bus_front #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .x16_sel(x16_sel), .id_mode(id_mode), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
  );

  typedef struct packed {
    logic          x16;
    logic          id;
    logic [AW-1:0] a;
    logic          lane;
    logic [15:0]   oe;
    logic [15:0]   dat;
  } rd_vec_t;

  localparam rd_vec_t RD_TBL [9] = '{
    '{1'b1, 1'b0, 18'h00123, 1'b0, 16'hFFFF, 16'h1F01},  // R2
    '{1'b0, 1'b0, 18'h00123, 1'b0, 16'h00FF, 16'h0001},  // R1 low lane
    '{1'b0, 1'b0, 18'h00123, 1'b1, 16'h00FF, 16'h001F},  // R1 high lane
    '{1'b1, 1'b0, 18'h3ABCD, 1'b0, 16'hFFFF, 16'hF1AB},  // R2
    '{1'b0, 1'b0, 18'h3ABCD, 1'b1, 16'h00FF, 16'h00F1},  // R1
    '{1'b1, 1'b1, 18'h00000, 1'b0, 16'hFFFF, 16'h00B7},  // R8 manufacturer
    '{1'b1, 1'b1, 18'h00001, 1'b0, 16'hFFFF, 16'h5A3C},  // R8 device
    '{1'b0, 1'b1, 18'h00001, 1'b1, 16'h00FF, 16'h003C},  // R9
    '{1'b0, 1'b1, 18'h00000, 1'b0, 16'h00FF, 16'h00B7}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_write(input logic x16, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [AW-1:0] ea, input logic [15:0] ed, input logic [1:0] ebe,
                          input string req);
    @(negedge clk);
    x16_sel = x16; id_mode = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = a; dq_in = d;
    @(negedge clk);
    chk("R4 oe ignored during strobe", {16'h0, dq_oe}, 32'h0);
    chk("R5 no write while strobe low", {31'h0, mem_wr_en}, 32'h0);
    we_n = 1'b1; addr = ~a; dq_in = ~d;   // junk after the rising edge
    @(negedge clk);
    chk({req, " wr_en"}, {31'h0, mem_wr_en}, 32'h1);
    chk({req, " addr"}, {14'h0, mem_wr_addr}, {14'h0, ea});
    chk({req, " data"}, {16'h0, mem_wr_data}, {16'h0, ed});
    chk({req, " be"}, {30'h0, mem_wr_be}, {30'h0, ebe});
    idle();
    @(negedge clk);
    chk("R5 single pulse", {31'h0, mem_wr_en}, 32'h0);
  endtask

  initial begin
    #(4 * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); x16_sel = 1'b1; id_mode = 1'b0; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk("R10 reset dq_oe", {16'h0, dq_oe}, 32'h0);
    chk("R10 reset wr_en", {31'h0, mem_wr_en}, 32'h0);
    idle();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      x16_sel = RD_TBL[i].x16; id_mode = RD_TBL[i].id; addr = RD_TBL[i].a;
      dq_in = {RD_TBL[i].lane, 15'h0}; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      #0;
      if (RD_TBL[i].id) chk("R8 no array read in id mode", {31'h0, mem_rd_en}, 32'h0);
      @(negedge clk);
      chk("R1/R2/R8/R9 read oe", {16'h0, dq_oe}, {16'h0, RD_TBL[i].oe});
      chk("R1/R2/R8/R9 read data", {16'h0, dq_out}, {16'h0, RD_TBL[i].dat});
    end

    // R11: output follows the previous sample, not the current pins
    x16_sel = 1'b1; id_mode = 1'b0; addr = 18'h00042; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    addr = 18'h00099;
    #1;
    chk("R11 one-cycle latency", {16'h0, dq_out}, {16'h0, 16'h7E00});
    @(negedge clk);
    chk("R11 new word next cycle", {16'h0, dq_out}, {16'h0, 16'hA500});

    // R3 chip deselected / output disabled
    ce_n = 1'b1;
    @(negedge clk);
    chk("R3 float on ce_n high", {16'h0, dq_oe}, 32'h0);
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    chk("R3 float on oe_n high", {16'h0, dq_oe}, 32'h0);
    idle();

    do_write(1'b0, 18'h01234, 16'h80A5, 18'h01234, 16'hA5A5, 2'b10, "R6 byte upper");
    do_write(1'b0, 18'h00777, 16'h005A, 18'h00777, 16'h5A5A, 2'b01, "R6 byte lower");
    do_write(1'b1, 18'h3FFFF, 16'hBEEF, 18'h3FFFF, 16'hBEEF, 2'b11, "R7 word");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule